// File: doc/BRIEF.md
# Odd-Byte Mapped Register Window

This block is a byte-wide register file that a 16-bit CPU bus reaches through a 16 KB address window. Only the odd byte lane carries registers. Each register is one byte wide, and neighbouring registers are two bus addresses apart. The lower part of the window holds a general bank of byte registers. A few entries of that bank drop certain bits on write, and a few start from nonzero values after reset. Two special byte registers sit near the top of the window: a kill register and a control register. Every other address in the window reads back a fixed filler byte, and writes to it are discarded.

The bus side presents a read or write strobe, a word/byte flag, a full byte address, eight bits of write data and the current open-bus value. A read returns sixteen bits one cycle after its strobe. The register byte goes in the low half. On a word read the upper half is taken from the open-bus input. A byte read from an even address gets the open-bus upper byte in its low half. Accesses whose address lies outside the window are ignored entirely.

Top module: `oddlane_regwin`

## Requirements
- R1: After reset every bank entry reads 0x00, except entry 0x7D, which reads 0x80, entry 0xB4, which reads 0x7F, and entry 222, which reads 0x08. The kill and control registers read 0x00.
- R2: An odd byte address A with window offset below 0x3E00 selects bank entry (offset − 1) / 2. A byte write there stores `wdata_i`, and a later byte read returns it in `rdata_o[7:0]` with `rdata_o[15:8]` = 0x00.
- R3: A byte write to an even address changes no register.
- R4: A write to entry 219 or 221 stores `wdata_i & 0x7F`. A write to entry 223 stores `wdata_i & 0xFE`. No other entry masks its write data.
- R5: Window offset 0x3E01 is the kill register and offset 0x3E03 is the control register. Each stores a full byte and reads it back.
- R6: A read from any other odd offset in the window returns 0x5D in the low byte. This covers bank indices of NREGS (256) and above below offset 0x3E00, and every offset from 0x3E00 up except kill and control. Writes to those offsets change no register.
- R7: A byte read from an even address returns `{8'h00, obus_i[15:8]}`.
- R8: A word access (`word_i` = 1) acts on address bit 0 forced to 1. A word write stores `wdata_i` as a byte write would. A word read returns `{obus_i[15:8], register byte}`.
- R9: `rvalid_o` is high in exactly the cycle after a read strobe to a window address, and `rdata_o` is valid in that cycle.
- R10: Reads and writes whose address bits above the window (bits 23:14) differ from 0x3BC000 do nothing. `rvalid_o` stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 8 | Write byte |
| obus_i | input | 16 | Current open-bus value |
| rdata_o | output | 16 | Read data, valid when rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |

## Verification
The hardest case to reach is a write that has no effect at a port where nothing else is visible. Examples are a write to an even address, a write to an unmapped offset, or a write whose upper address bits alias the window from outside. To catch these, the stimulus writes a distinctive byte through the faulty path and then reads the entry that the write could have reached. It does this for bank entries, for kill and control, and for out-of-window aliases that share the same low bits. Masked entries are exercised with all-ones and alternating patterns, so that each dropped bit shows up on readback. A long run of random accesses over every region of the window, including word and byte accesses at both address parities, is compared against the reference model on every clock.

// File: rtl/oddlane_regwin.sv
module oddlane_regwin #(
  parameter int ADDR_W = 24,
  parameter int WIN_BITS = 14,
  parameter logic [ADDR_W-1:0] BASE = 24'h3BC000,
  parameter int NREGS = 256,
  parameter logic [7:0] UNMAPPED = 8'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [15:0]       obus_i,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [WIN_BITS-1:0] TOP_OFF  = WIN_BITS'((1 << WIN_BITS) - 512);
  localparam logic [WIN_BITS-1:0] KILL_OFF = TOP_OFF + WIN_BITS'(1);
  localparam logic [WIN_BITS-1:0] CTRL_OFF = TOP_OFF + WIN_BITS'(3);
  localparam logic [WIN_BITS-2:0] NREGS_W  = (WIN_BITS-1)'(NREGS);

  function automatic logic [7:0] wmask(input logic [IDX_W-1:0] i);
    if (i == IDX_W'(219) || i == IDX_W'(221)) return 8'h7F;
    if (i == IDX_W'(223)) return 8'hFE;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] init_val(input int i);
    case (i)
      'h7D: return 8'h80;
      'hB4: return 8'h7F;
      222:  return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] bank [NREGS];
  logic [7:0] kill_q, ctrl_q, rsel;
  logic [WIN_BITS-1:0] eff_off;
  logic [WIN_BITS-2:0] idx_full;
  logic [IDX_W-1:0] idx;
  logic in_win, odd, bank_hit, is_kill, is_ctrl, wr_ok, rd_ok;

  assign in_win   = addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS];
  assign eff_off  = {addr_i[WIN_BITS-1:1], addr_i[0] | word_i};
  assign odd      = eff_off[0];
  assign idx_full = eff_off[WIN_BITS-1:1];
  assign idx      = idx_full[IDX_W-1:0];
  assign bank_hit = odd && (eff_off < TOP_OFF) && (idx_full < NREGS_W);
  assign is_kill  = eff_off == KILL_OFF;
  assign is_ctrl  = eff_off == CTRL_OFF;
  assign wr_ok    = wr_i && in_win && odd;
  assign rd_ok    = rd_i && in_win;

  always_comb begin
    rsel = UNMAPPED;
    if (bank_hit)     rsel = bank[idx];
    else if (is_kill) rsel = kill_q;
    else if (is_ctrl) rsel = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= init_val(i);
      kill_q <= 8'h00;
      ctrl_q <= 8'h00;
    end else if (wr_ok) begin
      if (bank_hit)     bank[idx] <= wdata_i & wmask(idx);
      else if (is_kill) kill_q <= wdata_i;
      else if (is_ctrl) ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 16'h0000;
    end else begin
      rvalid_o <= rd_ok;
      if (rd_ok)
        rdata_o <= odd ? {word_i ? obus_i[15:8] : 8'h00, rsel} : {8'h00, obus_i[15:8]};
    end
  end
endmodule

module oddlane_regwin_chk #(
  parameter int ADDR_W = 24,
  parameter int WIN_BITS = 14,
  parameter logic [ADDR_W-1:0] BASE = 24'h3BC000,
  parameter int NREGS = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_i,
  input logic              word_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       obus_i,
  input logic [15:0]       rdata_o,
  input logic              rvalid_o
);
  logic win, odd_eff, unmapped;
  logic [WIN_BITS-1:0] off;
  assign win      = addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS];
  assign off      = addr_i[WIN_BITS-1:0] | WIN_BITS'(word_i);
  assign odd_eff  = off[0];
  assign unmapped = odd_eff && (((off >> 1) >= WIN_BITS'(NREGS) && off < WIN_BITS'((1 << WIN_BITS) - 512))
                    || (off >= WIN_BITS'((1 << WIN_BITS) - 512)
                        && off != WIN_BITS'((1 << WIN_BITS) - 511)
                        && off != WIN_BITS'((1 << WIN_BITS) - 509)));

  p_rvalid_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && win) |=> rvalid_o);
  p_rvalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && win) |=> !rvalid_o);
  p_even_byte_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && win && !word_i && !addr_i[0]) |=> (rdata_o == {8'h00, $past(obus_i[15:8])}));
  p_word_read_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && win && word_i) |=> (rdata_o[15:8] == $past(obus_i[15:8])));
  p_byte_read_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && win && !word_i) |=> (rdata_o[15:8] == 8'h00));
  p_unmapped_filler_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && win && unmapped) |=> (rdata_o[7:0] == 8'h5D));
endmodule

bind oddlane_regwin oddlane_regwin_chk #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE), .NREGS(NREGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .word_i(word_i), .addr_i(addr_i),
  .obus_i(obus_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/test_oddlane_regwin.sv
module test_oddlane_regwin;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'h3BC000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_i = 1'b0, wr_i = 1'b0, word_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [15:0] obus_i = 16'hA5C3;
  logic [15:0] rdata_o;
  logic rvalid_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m [256];
  logic [7:0] m_kill, m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  oddlane_regwin i_oddlane_regwin (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wr_i(wr_i), .word_i(word_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .obus_i(obus_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic bit in_window(int a);
    return (a >>> 14) == (BASE >>> 14);
  endfunction

  function automatic logic [7:0] model_byte(int eff);
    int off = eff - BASE;
    if (off < 'h3E00) begin
      int idx = (off - 1) / 2;
      return (idx < 256) ? m[idx] : 8'h5D;
    end
    if (off == 'h3E01) return m_kill;
    if (off == 'h3E03) return m_ctrl;
    return 8'h5D;
  endfunction

  task automatic model_write(int a, bit w, logic [7:0] d);
    int eff = w ? (a | 1) : a;
    int off = eff - BASE;
    if (!in_window(a) || (eff % 2) == 0) return;
    if (off < 'h3E00) begin
      int idx = (off - 1) / 2;
      if (idx < 256) begin
        if (idx == 219 || idx == 221) m[idx] = d & 8'h7F;
        else if (idx == 223) m[idx] = d & 8'hFE;
        else m[idx] = d;
      end
    end else if (off == 'h3E01) m_kill = d;
    else if (off == 'h3E03) m_ctrl = d;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m['h7D] = 8'h80; m['hB4] = 8'h7F; m[222] = 8'h08;
    m_kill = 8'h00; m_ctrl = 8'h00;
  endtask

  task automatic cmp(bit ok, string tag, logic [16:0] act, logic [16:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual valid/data %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit r, bit w, bit wd, int a, logic [7:0] d, string tag);
    logic exp_v;
    logic [15:0] exp_d;
    int eff = wd ? (a | 1) : a;
    rd_i = r; wr_i = w; word_i = wd; addr_i = a[23:0]; wdata_i = d;
    obus_i = 16'($urandom);
    exp_v = r && in_window(a);
    if ((eff % 2) == 0) exp_d = {8'h00, obus_i[15:8]};
    else exp_d = {wd ? obus_i[15:8] : 8'h00, model_byte(eff)};
    if (w) model_write(a, wd, d);
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    if (exp_v) cmp(rvalid_o && rdata_o == exp_d, tag, {rvalid_o, rdata_o}, {1'b1, exp_d});
    else cmp(!rvalid_o, tag, {rvalid_o, rdata_o}, {1'b0, rdata_o});
  endtask

  function automatic int reg_addr(int idx);
    return BASE + 1 + 2 * idx;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    access(0, 0, 0, BASE, 0, "R9 idle after reset");
    for (int i = 0; i < 256; i++) access(1, 0, 0, reg_addr(i), 0, "R1 reset bank");
    access(1, 0, 0, BASE + 'h3E01, 0, "R1 reset kill");
    access(1, 0, 0, BASE + 'h3E03, 0, "R1 reset control");
    for (int i = 0; i < 256; i += 17) access(0, 1, 0, reg_addr(i), 8'(i * 7 + 3), "R2 write");
    for (int i = 0; i < 256; i += 17) access(1, 0, 0, reg_addr(i), 0, "R2 readback");
    access(0, 1, 0, reg_addr(5) - 1, 8'hEE, "R3 even write");
    access(0, 1, 0, reg_addr(6) - 1, 8'hEE, "R3 even write");
    access(1, 0, 0, reg_addr(5), 0, "R3 entry untouched");
    access(1, 0, 0, reg_addr(4), 0, "R3 entry untouched");
    foreach (m[k]) begin end
    for (int j = 0; j < 2; j++) begin
      logic [7:0] pat = j ? 8'hAA : 8'hFF;
      access(0, 1, 0, reg_addr(219), pat, "R4 mask write");
      access(0, 1, 0, reg_addr(221), pat, "R4 mask write");
      access(0, 1, 0, reg_addr(223), pat, "R4 mask write");
      access(0, 1, 0, reg_addr(220), pat, "R4 plain write");
      access(1, 0, 0, reg_addr(219), 0, "R4 entry 219");
      access(1, 0, 0, reg_addr(221), 0, "R4 entry 221");
      access(1, 0, 0, reg_addr(223), 0, "R4 entry 223");
      access(1, 0, 0, reg_addr(220), 0, "R4 entry 220 unmasked");
    end
    access(0, 1, 0, BASE + 'h3E01, 8'h9C, "R5 kill write");
    access(0, 1, 1, BASE + 'h3E02, 8'h37, "R5 control word write");
    access(1, 0, 0, BASE + 'h3E01, 0, "R5 kill read");
    access(1, 0, 0, BASE + 'h3E03, 0, "R5 control read");
    access(0, 1, 0, reg_addr(256), 8'h11, "R6 unmapped write");
    access(0, 1, 0, BASE + 'h3E05, 8'h22, "R6 unmapped write");
    access(1, 0, 0, reg_addr(256), 0, "R6 unmapped bank index");
    access(1, 0, 0, reg_addr('h1EFF), 0, "R6 last low unmapped");
    access(1, 0, 0, BASE + 'h3E05, 0, "R6 top unmapped");
    access(1, 0, 0, BASE + 'h3FFF, 0, "R6 window end");
    access(1, 0, 0, reg_addr(0), 0, "R6 entry 0 untouched");
    access(1, 0, 0, BASE + 'h3E01, 0, "R6 kill untouched");
    access(1, 0, 0, reg_addr(3) - 1, 0, "R7 even byte read");
    access(1, 0, 0, BASE + 'h3E00, 0, "R7 even byte read top");
    access(0, 1, 1, reg_addr(9) - 1, 8'h6B, "R8 word write");
    access(1, 0, 1, reg_addr(9) - 1, 0, "R8 word read");
    access(1, 0, 0, reg_addr(9), 0, "R8 byte readback");
    access(1, 0, 1, BASE + 'h3E04, 0, "R8 word read unmapped");
    access(0, 1, 0, reg_addr(0) - 'h4000, 8'hF0, "R10 outside write");
    access(0, 1, 0, reg_addr(0) + 'h4000, 8'hF1, "R10 outside write");
    access(1, 0, 0, reg_addr(0) + 'h4000, 0, "R10 outside read");
    access(1, 0, 0, reg_addr(0), 0, "R10 alias untouched");
    access(1, 1, 0, reg_addr(2), 8'h44, "R9 no read on plain idle");
    for (int i = 0; i < 600; i++) begin
      int a;
      int sel = int'($urandom % 8);
      if (sel < 4) a = BASE + int'($urandom % 'h220);
      else if (sel < 5) a = BASE + 'h3E00 + int'($urandom % 8);
      else if (sel < 7) a = BASE + int'($urandom % 'h4000);
      else a = BASE + 'h4000 + int'($urandom % 'h4000);
      if ($urandom % 2) access(1, 0, 1'($urandom), a, 0, "R9 random read");
      else access(0, 1, 1'($urandom), a, 8'($urandom), "R2 random write");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule